// File: doc/BRIEF.md
# Instruction-Steered Bidirectional Port Unit

This unit owns two 4-bit bidirectional ports that a small controller drives with single-cycle port instructions. Each instruction arrives as a one-cycle strobe that carries a port select, an operation code and a 4-bit argument. The argument is a data word or a bit mask, depending on the operation. The unit keeps an output latch for each port, drives the pins and their output enables, and returns a registered result for the instructions that read a port.

Port A has no direction register. Its direction is set by the kind of instruction last executed on it. Read-type instructions (read, all-ones test, all-zeros test) put all four pins into input mode. Write-type instructions (write, bit set, bit clear) put all four pins into output mode. Port B takes its direction from a 4-bit mask, one bit per pin, which is loaded by a dedicated instruction. When reset is active, both ports are inputs. In backup mode, both ports are forced to input and their read path is blocked.

The instruction interface is a plain control strobe: it is accepted every cycle with no back-pressure. The result interface is a one-cycle valid pulse with no ready, and the consumer must take it in that cycle.

Top module: `insport_unit`

## Requirements
- R1: `ins_port` 0 selects port A and 1 selects port B. The `ins_op` codes are: 0 no-op, 1 read, 2 write, 3 bit set, 4 bit clear, 5 all-ones test, 6 all-zeros test, 7 load direction mask. In the mask, bit i at 1 makes pin i an output.
- R2: On port A, a read, all-ones test or all-zeros test switches all four pins to input (`pa_oe`=0). The change shows in the strobe cycle itself and holds until a write-type instruction arrives.
- R3: On port A, a write, bit set or bit clear switches all four pins to output (`pa_oe`=4'hF) in the strobe cycle. The pins drive the value already held in the output latch.
- R4: Port B's `pb_oe` equals its direction mask, which a load-direction-mask instruction sets from `ins_arg` starting in the next cycle. A load-direction-mask instruction aimed at port A has no effect.
- R5: While `rst_n` is low, both ports are inputs (`*_oe`=0), and the output latches, port A mode and port B mask clear to 0.
- R6: While `backup` is 1, both output enables are 0, and read and test instructions see an input value of 0.
- R7: A write loads the latch with `ins_arg`. A bit set makes the masked bits 1 and a bit clear makes them 0, leaving the other bits as they were. `*_out` shows the new latch value from the cycle after the strobe.
- R8: An all-ones test reports skip=1 when every masked bit reads 1. An all-zeros test reports skip=1 when every masked bit reads 0. A read reports skip=0.
- R9: The value seen by a read or test returns the latch bit for output pins and the `*_in` pin for input pins. A read returns this value in `res_data`.
- R10: Each read, all-ones test or all-zeros test produces exactly one `res_valid` pulse in the cycle after its strobe. Other instructions, including no-ops, produce none and leave the port state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| backup | input | 1 | Backup mode: ports forced to input, reads blocked |
| ins_valid | input | 1 | Instruction strobe, one cycle per instruction |
| ins_port | input | 1 | Port select (0 = A, 1 = B) |
| ins_op | input | 3 | Operation code |
| ins_arg | input | 4 | Data word or bit mask |
| pa_in | input | 4 | Port A pin input |
| pa_out | output | 4 | Port A output latch to the pins |
| pa_oe | output | 4 | Port A output enables |
| pb_in | input | 4 | Port B pin input |
| pb_out | output | 4 | Port B output latch to the pins |
| pb_oe | output | 4 | Port B output enables |
| res_valid | output | 1 | Result valid pulse |
| res_data | output | 4 | Value seen by the read or test |
| res_skip | output | 1 | Test outcome (1 = skip) |

## Verification
The assertions assume that `ins_valid`, `ins_port`, `ins_op`, `ins_arg` and `backup` are stable and known for a whole clock cycle. They also assume the result consumer never stalls, because the pulse has no ready. The stimulus changes every input only at the falling clock edge and issues at most one instruction per cycle. It walks port A through mode changes in both directions and loads several masks into port B. It also enters and leaves backup mode and applies reset in the middle of the run.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int OPW = 3;

  typedef enum logic [OPW-1:0] {
    OP_NOP    = 3'd0,
    OP_READ   = 3'd1,
    OP_WRITE  = 3'd2,
    OP_BSET   = 3'd3,
    OP_BCLR   = 3'd4,
    OP_TONES  = 3'd5,
    OP_TZEROS = 3'd6,
    OP_DIRLD  = 3'd7
  } pio_op_e;

  function automatic logic is_read_kind(pio_op_e op);
    return (op == OP_READ) || (op == OP_TONES) || (op == OP_TZEROS);
  endfunction

  function automatic logic is_write_kind(pio_op_e op);
    return (op == OP_WRITE) || (op == OP_BSET) || (op == OP_BCLR);
  endfunction
endpackage

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter int W        = 4,
  parameter bit IMPLICIT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         backup,
  input  logic         sel,
  input  pio_op_e      op,
  input  logic [W-1:0] arg,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] rd_val
);
  logic [W-1:0] latch_q;
  logic [W-1:0] dir_eff;

  // Direction source: implicit mode bit or explicit per-pin mask
  generate
    if (IMPLICIT) begin : g_impl
      logic out_mode_q;
      always_comb begin
        dir_eff = {W{out_mode_q}};
        if (sel && is_read_kind(op))  dir_eff = '0;
        if (sel && is_write_kind(op)) dir_eff = '1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_mode_q <= 1'b0;
        else        out_mode_q <= dir_eff[0];
      end

      assert_in_mode_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && is_read_kind(op)) |=> (backup || (sel && is_write_kind(op)) || pin_oe == '0));
      assert_out_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && is_write_kind(op) && !backup) |-> (pin_oe == '1 && pin_out == latch_q));
    end else begin : g_mask
      logic [W-1:0] dmask_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       dmask_q <= '0;
        else if (sel && op == OP_DIRLD)   dmask_q <= arg;
      end
      assign dir_eff = dmask_q;

      assert_mask_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && op == OP_DIRLD) |=> (backup || pin_oe == $past(arg)));
    end
  endgenerate

  // Output latch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
    end else if (sel) begin
      case (op)
        OP_WRITE: latch_q <= arg;
        OP_BSET:  latch_q <= latch_q | arg;
        OP_BCLR:  latch_q <= latch_q & ~arg;
        default:  latch_q <= latch_q;
      endcase
    end
  end

  assign pin_out = latch_q;
  assign pin_oe  = (rst_n && !backup) ? dir_eff : '0;
  assign rd_val  = backup ? '0 : ((dir_eff & latch_q) | (~dir_eff & pin_in));

  always_comb begin
    if (!rst_n) assert_reset_input_R5: assert (pin_oe == '0);
  end

  assert_backup_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
    backup |-> (pin_oe == '0 && rd_val == '0));
  assert_bit_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && op == OP_BSET) |=> ((pin_out & $past(arg)) == $past(arg)));
  assert_bit_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && op == OP_BCLR) |=> ((pin_out & $past(arg)) == '0));
  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(pin_out));
endmodule

// File: rtl/pio_result.sv
module pio_result
  import pio_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  pio_op_e      op,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] value,
  output logic         res_valid,
  output logic [W-1:0] res_data,
  output logic         res_skip
);
  logic [W-1:0] hit;
  logic         skip_c;

  assign hit = value & mask;

  always_comb begin
    case (op)
      OP_TONES:  skip_c = (hit == mask);
      OP_TZEROS: skip_c = (hit == '0);
      default:   skip_c = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_skip  <= 1'b0;
    end else begin
      res_valid <= take;
      if (take) begin
        res_data <= value;
        res_skip <= skip_c;
      end
    end
  end

  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> res_valid);
  assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> !res_valid);
  assert_read_noskip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op == OP_READ) |=> !res_skip);
endmodule

// File: rtl/insport_unit.sv
module insport_unit
  import pio_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         backup,
  input  logic         ins_valid,
  input  logic         ins_port,
  input  logic [2:0]   ins_op,
  input  logic [W-1:0] ins_arg,
  input  logic [W-1:0] pa_in,
  output logic [W-1:0] pa_out,
  output logic [W-1:0] pa_oe,
  input  logic [W-1:0] pb_in,
  output logic [W-1:0] pb_out,
  output logic [W-1:0] pb_oe,
  output logic         res_valid,
  output logic [W-1:0] res_data,
  output logic         res_skip
);
  pio_op_e      op;
  logic         sel_a, sel_b, take;
  logic [W-1:0] rd_a, rd_b, rd_sel;

  assign op    = pio_op_e'(ins_op);
  assign sel_a = ins_valid && !ins_port;
  assign sel_b = ins_valid &&  ins_port;
  assign take  = ins_valid && is_read_kind(op);
  assign rd_sel = ins_port ? rd_b : rd_a;

  pio_port #(.W(W), .IMPLICIT(1'b1)) u_port_a (
    .clk(clk), .rst_n(rst_n), .backup(backup), .sel(sel_a), .op(op),
    .arg(ins_arg), .pin_in(pa_in), .pin_out(pa_out), .pin_oe(pa_oe), .rd_val(rd_a)
  );

  pio_port #(.W(W), .IMPLICIT(1'b0)) u_port_b (
    .clk(clk), .rst_n(rst_n), .backup(backup), .sel(sel_b), .op(op),
    .arg(ins_arg), .pin_in(pb_in), .pin_out(pb_out), .pin_oe(pb_oe), .rd_val(rd_b)
  );

  pio_result #(.W(W)) u_result (
    .clk(clk), .rst_n(rst_n), .take(take), .op(op), .mask(ins_arg),
    .value(rd_sel), .res_valid(res_valid), .res_data(res_data), .res_skip(res_skip)
  );

  assert_backup_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && backup) |=> (res_data == '0));
  assert_dirld_a_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a && op == OP_DIRLD) |=> (backup || pa_oe == $past(pa_oe)));
endmodule

// File: tb/insport_unit_bench.sv
module insport_unit_bench;
  localparam logic [2:0] NOP = 3'd0, RD = 3'd1, WR = 3'd2, BS = 3'd3, BC = 3'd4,
                         T1 = 3'd5, T0 = 3'd6, DL = 3'd7;

  logic clk = 1'b0, rst_n = 1'b0, backup = 1'b0;
  logic ins_valid = 1'b0, ins_port = 1'b0;
  logic [2:0] ins_op = 3'd0;
  logic [3:0] ins_arg = 4'd0, pa_in = 4'd0, pb_in = 4'd0;
  logic [3:0] pa_out, pa_oe, pb_out, pb_oe, res_data;
  logic res_valid, res_skip;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // bench model
  logic [3:0] la = 0, lb = 0, mb = 0;
  bit ma = 0;
  logic [3:0] q_data[$];
  bit         q_skip[$];
  string      q_tag[$];

  insport_unit u_insport_unit (
    .clk(clk), .rst_n(rst_n), .backup(backup), .ins_valid(ins_valid),
    .ins_port(ins_port), .ins_op(ins_op), .ins_arg(ins_arg),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .res_valid(res_valid), .res_data(res_data), .res_skip(res_skip)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input bit p, input logic [2:0] op, input logic [3:0] a, input string tag);
    logic [3:0] dirv, lat, pin, val;
    bit sk;
    @(negedge clk);
    ins_valid = 1'b1; ins_port = p; ins_op = op; ins_arg = a;
    #1;
    if (!p) dirv = (op == RD || op == T1 || op == T0) ? 4'h0 :
                   (op == WR || op == BS || op == BC) ? 4'hF : {4{ma}};
    else    dirv = mb;
    lat = p ? lb : la;
    pin = p ? pb_in : pa_in;
    val = backup ? 4'h0 : ((dirv & lat) | (~dirv & pin));
    if (op == RD || op == T1 || op == T0) begin
      sk = (op == T1) ? ((val & a) == a) : (op == T0) ? ((val & a) == 4'h0) : 1'b0;
      q_data.push_back(val); q_skip.push_back(sk); q_tag.push_back(tag);
    end
    if (!p && !backup)
      chk(pa_oe == dirv, {tag, " same-cycle direction"}, pa_oe, dirv);
    @(posedge clk);
    if (!p) begin
      if (op == WR) la = a;
      if (op == BS) la = la | a;
      if (op == BC) la = la & ~a;
      if (op == RD || op == T1 || op == T0) ma = 0;
      if (op == WR || op == BS || op == BC) ma = 1;
    end else begin
      if (op == WR) lb = a;
      if (op == BS) lb = lb | a;
      if (op == BC) lb = lb & ~a;
      if (op == DL) mb = a;
    end
    #1 ins_valid = 1'b0; ins_op = NOP;
  endtask

  task automatic pins(input string tag);
    @(negedge clk);
    chk(pa_out == la, {tag, " pa_out"}, pa_out, la);
    chk(pb_out == lb, {tag, " pb_out"}, pb_out, lb);
    chk(pa_oe == (backup ? 4'h0 : {4{ma}}), {tag, " pa_oe"}, pa_oe, backup ? 4'h0 : {4{ma}});
    chk(pb_oe == (backup ? 4'h0 : mb), {tag, " pb_oe"}, pb_oe, backup ? 4'h0 : mb);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (q_data.size() == 0) begin
        chk(1'b0, "R10 unexpected result pulse", 1, 0);
      end else begin
        logic [3:0] d; bit s; string t;
        d = q_data.pop_front(); s = q_skip.pop_front(); t = q_tag.pop_front();
        chk(res_data == d, {t, " res_data"}, res_data, d);
        chk(res_skip == s, {t, " res_skip"}, res_skip, s);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      chk(q_data.size() == 0, "R10 missing result pulses", q_data.size(), 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(pa_oe == 0 && pb_oe == 0, "R5 oe during reset", {pa_oe, pb_oe}, 0);
    rst_n = 1'b1;
    pins("R5 after reset");

    issue(0, WR, 4'hA, "R3 write A");
    pins("R7 write A");
    issue(0, BS, 4'h5, "R7 set A");
    pins("R7 set A");
    issue(0, BC, 4'h3, "R7 clear A");
    pins("R7 clear A");

    pa_in = 4'h6;
    issue(0, RD, 4'h0, "R2 R9 read A");
    pins("R2 A stays input");
    issue(0, T1, 4'h6, "R8 ones test hit");
    issue(0, T1, 4'h7, "R8 ones test miss");
    issue(0, T0, 4'h9, "R8 zeros test hit");
    issue(0, T0, 4'h2, "R8 zeros test miss");
    issue(0, DL, 4'hF, "R4 dirld on A ignored");
    pins("R4 A still input");
    issue(0, NOP, 4'hF, "R10 nop");
    pins("R10 nop no change");
    issue(0, BS, 4'h0, "R3 held latch driven");
    pins("R3 A output holds C");

    // R1 port select: port B operations do not touch port A
    issue(1, DL, 4'h5, "R1 R4 load mask B");
    pins("R4 mask B");
    issue(1, WR, 4'hF, "R7 write B");
    pins("R7 write B");
    pb_in = 4'h0;
    issue(1, RD, 4'h0, "R9 read B mixed");
    issue(1, BC, 4'h4, "R7 clear B");
    pb_in = 4'hA;
    issue(1, T1, 4'hB, "R8 R9 ones test B");
    issue(1, DL, 4'hA, "R4 reload mask B");
    pins("R4 mask B again");

    backup = 1'b1;
    pa_in = 4'hF; pb_in = 4'hF;
    pins("R6 backup oe");
    issue(0, RD, 4'h0, "R6 backup read A");
    issue(1, T0, 4'hF, "R6 backup zeros test B");
    backup = 1'b0;
    pins("R6 after backup");

    @(negedge clk);
    rst_n = 1'b0;
    la = 0; lb = 0; mb = 0; ma = 0;
    #1 chk(pa_oe == 0 && pb_oe == 0, "R5 mid-run reset oe", {pa_oe, pb_oe}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    pins("R5 after mid-run reset");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule